// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This peripheral holds three independent 16-bit up-counters that share one input clock. Each channel has its own power-of-two prescaler, a control word that halts it, selects free-running or interval counting and restarts the count from zero, an interval limit, three compare values, a sticky event register and an event mask. One level-sensitive interrupt line per channel is raised whenever an unmasked event bit is set.

Software reaches the registers over a plain 32-bit write bus with a combinational read port. Registers of the same kind form a bank of three words, one per channel, and the banks follow one another every 12 bytes. An event is acknowledged by reading the event register and writing the value back; writing a one clears that bit.

Each channel works in one of three modes, decoded from its control word: HALT (stop bit set), FREE (stop clear, interval bit clear) and INTERVAL (stop clear, interval bit set). Every transition (HALT to FREE, HALT to INTERVAL, FREE to INTERVAL, and back) is a single write to the control word and takes effect from the next clock edge; the restart bit may accompany any of them.

Top module: `tri_timer`

## Requirements
- R1: After reset every channel reads control 0x01 (halted), clock control 0, count 0, interval 0, compare values 0, events 0, mask 0, and every interrupt line is low.
- R2: The register at byte offset 12*b + 4*c belongs to channel c (0..2) in bank b: 0 clock control, 1 control, 2 count (read-only), 3 interval, 4..6 compare 1..3, 7 events, 8 mask. Offsets beyond bank 8 read 0, and a write to the count bank has no effect.
- R3: Control bit 0 set holds the count; with it clear the count advances by one on every prescaler tick.
- R4: In FREE mode the count goes from 0xFFFF to 0 and continues, and event bit 0 is not set.
- R5: In INTERVAL mode (control bit 1) a tick taken while the count equals the interval value loads 0 and sets event bit 0.
- R6: Writing control bit 4 clears the count and the prescaler at that edge with no event; the bit always reads back 0, while bits 0, 1, 2, 3 and 5 read back as written.
- R7: Clock control bit 0 enables the prescaler and bits [4:1] hold N; a tick then comes every 2^(N+1) clocks (0x09 gives 32), otherwise every clock. A write to clock control restarts the prescaler phase.
- R8: Event bit k (1..3) is set when a tick brings the count to compare value k.
- R9: Event bits stay set until a write to the event register with a one in that position; an event in the same cycle as its clear leaves the bit set.
- R10: irq[c] is high exactly while channel c has some event bit and its mask bit both set.
- R11: The channels count, match and interrupt independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 7 | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 3 | Interrupt line per channel |

## Verification
On every cycle the assertions check that a halted channel keeps its count, that the count only holds, steps by one or returns to zero, that the restart bit zeroes the count, that an interval match both wraps and flags, and that event bits never drop without a write to the event register. What the assertions cannot see is the whole arithmetic of time: prescaler ratios over hundreds of clocks, the 65536-tick wrap, compare hits at the right count, the clear-versus-event race and the address map, which the bench shows by running a behavioural model of all three channels beside the design and comparing interrupt lines on every clock and register reads at chosen points.

// File: rtl/tri_timer_pkg.sv
package tri_timer_pkg;
    localparam int CNT_W     = 16;
    localparam int SEL_W     = 4;
    localparam int NUM_MATCH = 3;
    localparam int NUM_BANK  = 9;

    // bank indices; the byte offset order matters to software
    localparam int BANK_CLK = 0;
    localparam int BANK_CTL = 1;
    localparam int BANK_CNT = 2;
    localparam int BANK_IVL = 3;
    localparam int BANK_MT0 = 4;
    localparam int BANK_STS = 7;
    localparam int BANK_ENA = 8;

    localparam int CTL_STOP_BIT = 0;
    localparam int CTL_IVL_BIT  = 1;
    localparam int CTL_RST_BIT  = 4;
    localparam logic [5:0] CTL_KEEP_MASK = 6'h2F;
    localparam logic [5:0] CTL_RESET_VAL = 6'h01;

    typedef enum logic [1:0] {
        MODE_HALT,
        MODE_FREE,
        MODE_INTERVAL
    } ch_mode_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SEL_W = 4,
    localparam int PW = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             pre_en,
    input  logic [SEL_W-1:0] pre_sel,
    output logic             tick
);
    logic [PW-1:0] pcnt;
    logic [PW:0]   span;
    logic [PW-1:0] last;
    logic          wrap;

    always_comb begin
        span = ({{PW{1'b0}}, 1'b1} << ({1'b0, pre_sel} + 1'b1)) - 1'b1;
        last = span[PW-1:0];
        wrap = (pcnt == last);
        tick = run && (!pre_en || wrap);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clear)
            pcnt <= '0;
        else if (run && pre_en)
            pcnt <= wrap ? '0 : pcnt + 1'b1;
    end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tri_timer_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int SW  = SEL_W,
    parameter int NM  = NUM_MATCH,
    localparam int EW = NM + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we_clk,
    input  logic                  we_ctl,
    input  logic                  we_ivl,
    input  logic [NM-1:0]         we_match,
    input  logic                  we_sts,
    input  logic                  we_ena,
    input  logic [CW-1:0]         wdata,
    output logic [SW:0]           clk_ctl,
    output logic [5:0]            cnt_ctl,
    output logic [CW-1:0]         count,
    output logic [CW-1:0]         interval,
    output logic [NM-1:0][CW-1:0] match,
    output logic [EW-1:0]         sts,
    output logic [EW-1:0]         ena,
    output logic                  irq
);
    ch_mode_e      mode;
    logic          tick;
    logic          restart;
    logic          advanced;
    logic [CW-1:0] cnt_nxt;
    logic [EW-1:0] ev;
    logic [EW-1:0] sts_nxt;

    assign restart = we_ctl && wdata[CTL_RST_BIT];

    always_comb begin
        if (cnt_ctl[CTL_STOP_BIT])     mode = MODE_HALT;
        else if (cnt_ctl[CTL_IVL_BIT]) mode = MODE_INTERVAL;
        else                           mode = MODE_FREE;
    end

    tmr_prescale #(.SEL_W(SW)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart || we_clk),
        .run     (mode != MODE_HALT),
        .pre_en  (clk_ctl[0]),
        .pre_sel (clk_ctl[SW:1]),
        .tick    (tick)
    );

    // next count and interval event per mode
    always_comb begin
        cnt_nxt  = count;
        advanced = 1'b0;
        ev[0]    = 1'b0;
        unique case (mode)
            MODE_HALT: ;
            MODE_FREE: if (tick) begin
                cnt_nxt  = count + 1'b1;
                advanced = 1'b1;
            end
            MODE_INTERVAL: if (tick) begin
                advanced = 1'b1;
                if (count == interval) begin
                    cnt_nxt = '0;
                    ev[0]   = 1'b1;
                end else begin
                    cnt_nxt = count + 1'b1;
                end
            end
        endcase
        if (restart) begin
            cnt_nxt  = '0;
            advanced = 1'b0;
            ev[0]    = 1'b0;
        end
    end

    for (genvar k = 0; k < NM; k++) begin : g_match
        assign ev[k+1] = advanced && (cnt_nxt == match[k]);
    end

    assign sts_nxt = (we_sts ? (sts & ~wdata[EW-1:0]) : sts) | ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_ctl  <= '0;
            cnt_ctl  <= CTL_RESET_VAL;
            count    <= '0;
            interval <= '0;
            match    <= '0;
            sts      <= '0;
            ena      <= '0;
        end else begin
            count <= cnt_nxt;
            sts   <= sts_nxt;
            if (we_clk) clk_ctl  <= wdata[SW:0];
            if (we_ctl) cnt_ctl  <= wdata[5:0] & CTL_KEEP_MASK;
            if (we_ivl) interval <= wdata;
            if (we_ena) ena      <= wdata[EW-1:0];
            for (int k = 0; k < NM; k++)
                if (we_match[k]) match[k] <= wdata;
        end
    end

    assign irq = |(sts & ena);

    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALT && !we_ctl) |=> (count == $past(count)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 || count == '0));

    // R6
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (count == '0));

    // R5
    interval_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INTERVAL && tick && count == interval && !we_ctl)
        |=> (sts[0] && count == '0));

    // R9
    sticky_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_sts |=> ((sts & $past(sts)) == $past(sts)));
endmodule

// File: rtl/tri_timer.sv
module tri_timer
    import tri_timer_pkg::*;
#(
    parameter int NUM_CH = 3,
    localparam int AW   = $clog2(NUM_BANK * NUM_CH * 4),
    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int EW   = NUM_MATCH + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0][SEL_W:0]                  clk_ctl_a;
    logic [NUM_CH-1:0][5:0]                      cnt_ctl_a;
    logic [NUM_CH-1:0][CNT_W-1:0]                count_a;
    logic [NUM_CH-1:0][CNT_W-1:0]                ivl_a;
    logic [NUM_CH-1:0][NUM_MATCH-1:0][CNT_W-1:0] match_a;
    logic [NUM_CH-1:0][EW-1:0]                   sts_a;
    logic [NUM_CH-1:0][EW-1:0]                   ena_a;

    int        word_idx;
    int        bank_sel;
    logic [CH_W-1:0] ch_sel;

    always_comb begin
        word_idx = int'(bus_addr[AW-1:2]);
        bank_sel = word_idx / NUM_CH;
        ch_sel   = CH_W'(word_idx % NUM_CH);
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic                 hit;
        logic [NUM_MATCH-1:0] we_mt;
        assign hit = bus_we && (int'(ch_sel) == c);
        for (genvar k = 0; k < NUM_MATCH; k++) begin : g_mwe
            assign we_mt[k] = hit && (bank_sel == BANK_MT0 + k);
        end
        tmr_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .we_clk   (hit && bank_sel == BANK_CLK),
            .we_ctl   (hit && bank_sel == BANK_CTL),
            .we_ivl   (hit && bank_sel == BANK_IVL),
            .we_match (we_mt),
            .we_sts   (hit && bank_sel == BANK_STS),
            .we_ena   (hit && bank_sel == BANK_ENA),
            .wdata    (bus_wdata[CNT_W-1:0]),
            .clk_ctl  (clk_ctl_a[c]),
            .cnt_ctl  (cnt_ctl_a[c]),
            .count    (count_a[c]),
            .interval (ivl_a[c]),
            .match    (match_a[c]),
            .sts      (sts_a[c]),
            .ena      (ena_a[c]),
            .irq      (irq[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        case (bank_sel)
            BANK_CLK: bus_rdata = 32'(clk_ctl_a[ch_sel]);
            BANK_CTL: bus_rdata = 32'(cnt_ctl_a[ch_sel]);
            BANK_CNT: bus_rdata = 32'(count_a[ch_sel]);
            BANK_IVL: bus_rdata = 32'(ivl_a[ch_sel]);
            BANK_STS: bus_rdata = 32'(sts_a[ch_sel]);
            BANK_ENA: bus_rdata = 32'(ena_a[ch_sel]);
            default:
                if (bank_sel >= BANK_MT0 && bank_sel < BANK_MT0 + NUM_MATCH)
                    bus_rdata = 32'(match_a[ch_sel][bank_sel - BANK_MT0]);
        endcase
    end
endmodule

// File: tb/tri_timer_tb.sv
module tri_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit mon_on = 0;

    always #4 clk = ~clk;

    tri_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference model
    logic [4:0]  m_clk [3];
    logic [5:0]  m_ctl [3];
    logic [15:0] m_cnt [3];
    logic [15:0] m_ivl [3];
    logic [15:0] m_pc  [3];
    logic [15:0] m_mt  [3][3];
    logic [3:0]  m_sts [3];
    logic [3:0]  m_ena [3];

    int          w_b, w_c, ratio;
    bit          run, pen, tick, adv, rstb;
    logic [15:0] ncnt, npc;
    logic [3:0]  ev;

    function automatic bit hit(int bank, int c);
        return bus_we && w_b == bank && w_c == c;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin
                m_clk[c] = 0; m_ctl[c] = 6'h01; m_cnt[c] = 0; m_ivl[c] = 0;
                m_pc[c] = 0; m_sts[c] = 0; m_ena[c] = 0;
                for (int k = 0; k < 3; k++) m_mt[c][k] = 0;
            end
        end else begin
            w_b = (int'(bus_addr) >> 2) / 3;
            w_c = (int'(bus_addr) >> 2) % 3;
            for (int c = 0; c < 3; c++) begin
                run   = !m_ctl[c][0];
                pen   = m_clk[c][0];
                ratio = 1 << (int'(m_clk[c][4:1]) + 1);
                tick  = run && (!pen || int'(m_pc[c]) == ratio - 1);
                ev = 0; adv = 0; ncnt = m_cnt[c];
                if (tick) begin
                    adv = 1;
                    if (m_ctl[c][1] && m_cnt[c] == m_ivl[c]) begin ncnt = 0; ev[0] = 1; end
                    else ncnt = m_cnt[c] + 16'd1;
                end
                rstb = hit(1, c) && bus_wdata[4];
                if (rstb) begin ncnt = 0; adv = 0; ev = 0; end
                if (adv) for (int k = 0; k < 3; k++) if (ncnt == m_mt[c][k]) ev[k+1] = 1;
                if (hit(0, c) || rstb) npc = 0;
                else if (run && pen) npc = (int'(m_pc[c]) == ratio - 1) ? 16'd0 : m_pc[c] + 16'd1;
                else npc = m_pc[c];
                m_sts[c] = (hit(7, c) ? (m_sts[c] & ~bus_wdata[3:0]) : m_sts[c]) | ev;
                m_cnt[c] = ncnt;
                m_pc[c]  = npc;
                if (hit(0, c)) m_clk[c] = bus_wdata[4:0];
                if (hit(1, c)) m_ctl[c] = bus_wdata[5:0] & 6'h2F;
                if (hit(3, c)) m_ivl[c] = bus_wdata[15:0];
                for (int k = 0; k < 3; k++) if (hit(4 + k, c)) m_mt[c][k] = bus_wdata[15:0];
                if (hit(8, c)) m_ena[c] = bus_wdata[3:0];
            end
        end
    end

    function automatic logic [31:0] exp_read(logic [6:0] a);
        int b = (int'(a) >> 2) / 3;
        int c = (int'(a) >> 2) % 3;
        case (b)
            0: return 32'(m_clk[c]);
            1: return 32'(m_ctl[c]);
            2: return 32'(m_cnt[c]);
            3: return 32'(m_ivl[c]);
            4, 5, 6: return 32'(m_mt[c][b-4]);
            7: return 32'(m_sts[c]);
            8: return 32'(m_ena[c]);
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [6:0] A(int b, int c);
        return 7'(b * 12 + c * 4);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd_chk(logic [6:0] a, string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_read(a));
    endtask

    task automatic rd_val(logic [6:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // R10 / R11: interrupt lines against the model on every clock
    always @(negedge clk) begin
        if (mon_on)
            for (int c = 0; c < 3; c++)
                chk($sformatf("R10 irq ch%0d", c), 32'(irq[c]), 32'(|(m_sts[c] & m_ena[c])));
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v1, v2;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        mon_on = 1;

        // R1 / R2: reset values across the whole map
        for (int w = 0; w < 27; w++) rd_chk(7'(w * 4), "R1 reset map");
        rd_val(A(1, 1), v1); chk("R1 ctl reset", v1, 32'h01);
        chk("R1 irq reset", 32'(irq), 32'd0);

        // R2: count bank read-only, unmapped reads zero
        wr(A(2, 0), 32'h1234);
        rd_val(A(2, 0), v1); chk("R2 count write ignored", v1, 32'd0);
        rd_val(7'h6C, v1); chk("R2 unmapped read", v1, 32'd0);

        // R3: run then stop
        wr(A(1, 0), 32'h00);
        idle(10);
        rd_chk(A(2, 0), "R3 running count");
        wr(A(1, 0), 32'h01);
        rd_val(A(2, 0), v1);
        idle(7);
        rd_val(A(2, 0), v2);
        chk("R3 halted count stable", v2, v1);

        // R7: prescaler /32 then /2
        wr(A(0, 0), 32'h09);
        wr(A(1, 0), 32'h10);
        idle(200);
        rd_chk(A(2, 0), "R7 div32 count");
        rd_chk(A(0, 0), "R7 clk ctl readback");
        wr(A(0, 0), 32'h01);
        idle(21);
        rd_chk(A(2, 0), "R7 div2 count");

        // R6: restart bit reads back zero, other bits kept
        wr(A(1, 0), 32'h3F);
        rd_val(A(1, 0), v1); chk("R6 ctl readback", v1, 32'h2F);
        rd_chk(A(2, 0), "R6 restart count");

        // R5: interval wrap with interrupt on channel 2
        wr(A(3, 2), 32'd5);
        wr(A(8, 2), 32'h1);
        wr(A(1, 2), 32'h12);
        idle(30);
        rd_chk(A(2, 2), "R5 interval count");
        rd_chk(A(7, 2), "R5 interval flag");
        wr(A(1, 2), 32'h03);
        rd_val(A(7, 2), v1);
        wr(A(7, 2), v1);
        rd_val(A(7, 2), v2); chk("R9 ack clears", v2, 32'd0);
        chk("R10 irq after ack", 32'(irq[2]), 32'd0);

        // R8: compare hits on channel 1
        wr(A(4, 1), 32'd3);
        wr(A(5, 1), 32'd7);
        wr(A(6, 1), 32'd9);
        wr(A(8, 1), 32'hE);
        wr(A(1, 1), 32'h10);
        idle(12);
        rd_val(A(7, 1), v1); chk("R8 compare flags", v1, 32'hE);
        wr(A(1, 1), 32'h01);

        // R9: event in the same cycle as its clear wins
        wr(A(0, 0), 32'h00);
        wr(A(3, 0), 32'd0);
        wr(A(1, 0), 32'h12);
        wr(A(7, 0), 32'hF);
        rd_val(A(7, 0), v1); chk("R9 event beats clear", 32'(v1[0]), 32'd1);
        rd_chk(A(7, 0), "R9 status model");
        wr(A(1, 0), 32'h01);

        // R11: channel 2 unaffected while others ran
        rd_chk(A(2, 2), "R11 idle channel count");

        // R4: free-running wrap on channel 1
        wr(A(8, 1), 32'h0);
        wr(A(7, 1), 32'hF);
        wr(A(1, 1), 32'h10);
        idle(65545);
        rd_chk(A(2, 1), "R4 wrapped count");
        rd_val(A(7, 1), v1); chk("R4 no interval flag", 32'(v1[0]), 32'd0);
        rd_chk(A(7, 1), "R4 status model");

        mon_on = 0;
        finished = 1;
        summary();
        $finish;
    end
endmodule